// File: doc/BRIEF.md
# Serial-In Shift-and-Store Register

This block turns a serial bit stream into a parallel word. On every rising edge of the shift clock, a new bit enters the first of eight shift stages, and every other stage takes the bit of its neighbour. Each shift stage has its own storage stage. The storage stage is a level-sensitive latch, so the held word follows the shift stages while the strobe is high and freezes when the strobe falls. Shifting can therefore go on without disturbing the word on the parallel outputs.

The parallel outputs appear as a data vector and a drive flag, standing in for three-state pins. When the output enable is low, the flag is low and the vector reads all zero. Two cascade outputs carry the last stage's bit so that several registers can be chained. The fast one follows the rising edge. The slow one copies it on the following falling edge, which gives the next device in the chain half a clock period of hold time when the clock edges are slow.

A synchronous active-high reset clears the shift stages and the cascade flop on the clock edge. It clears the storage stages for as long as it is held.

Top module: `shift_store_reg`

## Requirements
- R1: While `rst` is high at a rising edge, every shift stage becomes 0. While `rst` is high, the storage stages read 0. `casc_slow` becomes 0 at a falling edge taken with `rst` high.
- R2: At each rising edge of `clk` with `rst` low, stage 0 takes `ser_in` and stage k takes the previous value of stage k-1, for k from 1 to STAGES-1.
- R3: While `strobe` is high, the storage stage k follows shift stage k with no clock edge needed. `par_q[0]` maps to stage 0, the stage fed by `ser_in`, and `par_q[STAGES-1]` maps to the last stage.
- R4: While `strobe` is low, the storage stages keep their value, whatever shifting takes place.
- R5: With `out_en` high, `par_drive` is 1 and `par_q` presents the storage stages. With `out_en` low, `par_drive` is 0 (undriven) and `par_q` reads all zero.
- R6: `casc_fast` equals the last shift stage, so it changes only just after a rising edge.
- R7: `casc_slow` takes the value of `casc_fast` at each falling edge. It therefore lags `casc_fast` by half a clock period.
- R8: `casc_fast` and `casc_slow` do not depend on `out_en` or `strobe`.
- R9: With `casc_fast` of one register feeding `ser_in` of a second, the first bit of 16 shifted bits ends in the last stage of the second register, and the 16th bit ends in stage 0 of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages advance on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High: storage latches are transparent; low: they hold |
| out_en | input | 1 | Enables the parallel outputs |
| par_q | output | STAGES | Held word, bit k from storage stage k; zero when undriven |
| par_drive | output | 1 | High when the parallel outputs are driven |
| casc_fast | output | 1 | Last stage bit, updated on the rising edge |
| casc_slow | output | 1 | Last stage bit, re-timed to the falling edge |

## Verification
Two registers are chained and fed a mixed 16-bit word. The result shows that bit order and the crossing between the two registers are right, since a reversed stage order or a missing cascade gives a different pair of words. A hold phase shifts a walking one with the strobe low and then toggles the output enable. A mis-wired latch enable would let the held word drift, and a faulty gate would leave data on an undriven bus. A transparent phase keeps the strobe high while alternating bits stream in, which tells a true level latch from an edge-captured one. Each clock, `casc_slow` is compared just after the rising edge against the last-stage bit from before that edge. This exposes a slow tap that is clocked on the wrong edge.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int SSR_STAGES = 8;

    typedef enum logic {
        PAR_FLOAT  = 1'b0,
        PAR_DRIVEN = 1'b1
    } par_mode_e;

    typedef struct packed {
        logic fast;
        logic slow;
    } casc_pair_t;

    function automatic par_mode_e mode_of(input logic enable);
        return enable ? PAR_DRIVEN : PAR_FLOAT;
    endfunction

endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
    parameter int STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output logic [STAGES-1:0] stage_q
);

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic feed;
        if (k == 0) begin : g_head
            assign feed = din;
        end else begin : g_body
            assign feed = stage_q[k-1];
        end
        always_ff @(posedge clk) begin
            if (rst) stage_q[k] <= 1'b0;
            else     stage_q[k] <= feed;
        end
    end

    // R2: each rising edge moves the word up by one and takes din at the bottom
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stage_q == {$past(stage_q[STAGES-2:0]), $past(din)}));

endmodule

// File: rtl/ssr_store_latch.sv
module ssr_store_latch #(
    parameter int STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [STAGES-1:0] din_vec,
    output logic [STAGES-1:0] hold_q
);

    always_latch begin
        if (rst)         hold_q <= '0;
        else if (strobe) hold_q <= din_vec;
    end

    // R3: with the strobe open the held word mirrors the shift stages
    a_r3_transparent: assert property (@(negedge clk) disable iff (rst)
        strobe |-> (hold_q == din_vec));

endmodule

// File: rtl/ssr_out_gate.sv
module ssr_out_gate #(
    parameter int STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              out_en,
    input  logic [STAGES-1:0] hold_q,
    output logic [STAGES-1:0] par_q,
    output logic              par_drive
);
    import ssr_pkg::*;

    par_mode_e mode;

    always_comb begin
        mode      = mode_of(out_en);
        par_drive = (mode == PAR_DRIVEN);
        par_q     = (mode == PAR_DRIVEN) ? hold_q : '0;
    end

endmodule

// File: rtl/ssr_cascade_tap.sv
module ssr_cascade_tap (
    input  logic                clk,
    input  logic                rst,
    input  logic                last_bit,
    output ssr_pkg::casc_pair_t casc
);

    logic slow_q;

    always_ff @(negedge clk) begin
        if (rst) slow_q <= 1'b0;
        else     slow_q <= last_bit;
    end

    assign casc.fast = last_bit;
    assign casc.slow = slow_q;

    // R7: by the next rising edge the slow tap has caught up with the fast one
    a_r7_half_lag: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (casc.slow == casc.fast));

endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
    parameter int STAGES = ssr_pkg::SSR_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              out_en,
    output logic [STAGES-1:0] par_q,
    output logic              par_drive,
    output logic              casc_fast,
    output logic              casc_slow
);
    import ssr_pkg::*;

    logic [STAGES-1:0] stage_w;
    logic [STAGES-1:0] hold_w;
    casc_pair_t        casc_w;

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .din     (ser_in),
        .stage_q (stage_w)
    );

    ssr_store_latch #(.STAGES(STAGES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .din_vec (stage_w),
        .hold_q  (hold_w)
    );

    ssr_out_gate #(.STAGES(STAGES)) u_gate (
        .out_en    (out_en),
        .hold_q    (hold_w),
        .par_q     (par_q),
        .par_drive (par_drive)
    );

    ssr_cascade_tap u_tap (
        .clk      (clk),
        .rst      (rst),
        .last_bit (stage_w[STAGES-1]),
        .casc     (casc_w)
    );

    assign casc_fast = casc_w.fast;
    assign casc_slow = casc_w.slow;

    // R6: the fast tap shows the bit that sat one stage below the top before the edge
    a_r6_fast_last: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (casc_fast == $past(stage_w[STAGES-2])));

endmodule

// File: tb/shift_store_reg_test.sv
module shift_store_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic strobe = 1'b0;
    logic out_en = 1'b1;

    logic [N-1:0] par_a, par_b;
    logic drv_a, drv_b;
    logic fast_a, slow_a, fast_b, slow_b;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_store_reg #(.STAGES(N)) uut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .strobe(strobe), .out_en(out_en),
        .par_q(par_a), .par_drive(drv_a), .casc_fast(fast_a), .casc_slow(slow_a)
    );

    shift_store_reg #(.STAGES(N)) uut_tail (
        .clk(clk), .rst(rst), .ser_in(fast_a), .strobe(strobe), .out_en(out_en),
        .par_q(par_b), .par_drive(drv_b), .casc_fast(fast_b), .casc_slow(slow_b)
    );

    // Behavioural reference: one bit queue spans both registers, element 0 newest
    bit chain[$];
    logic [N-1:0] store_a_m, store_b_m;
    bit prev_fast_a, prev_fast_b;

    function automatic logic [N-1:0] slice(input int base);
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = chain[base + k];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        chain.delete();
        for (int k = 0; k < 2*N; k++) chain.push_back(1'b0);
        store_a_m = '0;
        store_b_m = '0;
    endtask

    task automatic check_all();
        logic [N-1:0] ea, eb;
        ea = out_en ? store_a_m : '0;
        eb = out_en ? store_b_m : '0;
        chk(par_a == ea, "R5/R3/R4 head word", par_a, ea);
        chk(par_b == eb, "R5/R3/R4 tail word", par_b, eb);
        chk(drv_a == out_en, "R5 head drive", drv_a, out_en);
        chk(drv_b == out_en, "R5 tail drive", drv_b, out_en);
        chk(fast_a == chain[N-1], "R6/R8 head fast", fast_a, chain[N-1]);
        chk(fast_b == chain[2*N-1], "R6/R8 tail fast", fast_b, chain[2*N-1]);
        chk(slow_a == chain[N-1], "R7 head slow after fall", slow_a, chain[N-1]);
        chk(slow_b == chain[2*N-1], "R7 tail slow after fall", slow_b, chain[2*N-1]);
    endtask

    // One clock: called at posedge+8, drives inputs, crosses the edge, checks twice
    task automatic cycle(input bit d, input bit s, input bit o);
        ser_in = d;
        strobe = s;
        out_en = o;
        if (s) begin
            store_a_m = slice(0);
            store_b_m = slice(N);
        end
        prev_fast_a = chain[N-1];
        prev_fast_b = chain[2*N-1];
        @(posedge clk);
        chain.push_front(d);
        void'(chain.pop_back());
        #1;
        // R7: just after the rise the slow tap still holds the pre-edge bit
        chk(slow_a == prev_fast_a, "R7 head lag", slow_a, prev_fast_a);
        chk(slow_b == prev_fast_b, "R7 tail lag", slow_b, prev_fast_b);
        chk(fast_a == chain[N-1], "R6 head fast at rise", fast_a, chain[N-1]);
        if (s) begin
            store_a_m = slice(0);
            store_b_m = slice(N);
        end
        #(CLK_PERIOD - 3);
        check_all();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] word;
        model_reset();
        rst = 1'b1;
        ser_in = 1'b1;
        strobe = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        strobe = 1'b0;
        #6;
        // R1: everything zero after reset
        chk(par_a == '0, "R1 head store cleared", par_a, 0);
        chk(par_b == '0, "R1 tail store cleared", par_b, 0);
        chk(fast_a == 1'b0 && slow_a == 1'b0, "R1 head cascade cleared", {fast_a, slow_a}, 0);
        chk(fast_b == 1'b0 && slow_b == 1'b0, "R1 tail cascade cleared", {fast_b, slow_b}, 0);

        // R2/R4/R9: shift a 16-bit word with the strobe closed
        word = 16'hA5C3;
        for (int i = 15; i >= 0; i--) cycle(word[i], 1'b0, 1'b1);
        chk(par_a == '0, "R4 head held during shifting", par_a, 0);
        // R9: open the strobe for one cycle of shifting a 0
        cycle(1'b0, 1'b1, 1'b1);
        cycle(1'b0, 1'b0, 1'b1);
        // after 17 shifts, stage k of the chain holds word bit (k-1); word[15] fell off
        chk(par_b == word[14:7], "R9 tail word", par_b, word[14:7]);
        chk(par_a == {word[6:0], 1'b0}, "R9 head word and R3 bit order", par_a, {word[6:0], 1'b0});

        // R4: walking one with strobe low, word must not move
        for (int i = 0; i < 12; i++) cycle(i == 0, 1'b0, 1'b1);
        chk(par_b == word[14:7], "R4 tail held", par_b, word[14:7]);

        // R5/R8: output enable off, cascade keeps running
        for (int i = 0; i < 6; i++) cycle(i[0], 1'b0, 1'b0);
        chk(par_a == '0 && drv_a == 1'b0, "R5 undriven head", {drv_a, par_a}, 0);
        for (int i = 0; i < 4; i++) cycle(i[1], 1'b1, 1'b0);
        chk(par_b == '0 && drv_b == 1'b0, "R5/R8 undriven tail while strobe open", {drv_b, par_b}, 0);

        // R3: transparent streaming with alternating bits
        for (int i = 0; i < 20; i++) cycle(i[0], 1'b1, 1'b1);
        // R3: strobe raised between edges passes the word with no edge
        strobe = 1'b0;
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b1);
        strobe = 1'b1;
        #1;
        chk(par_a == slice(0), "R3 level transparency", par_a, slice(0));
        store_a_m = slice(0);
        store_b_m = slice(N);

        // R1: reset mid-run
        rst = 1'b1;
        @(posedge clk);
        #8;
        model_reset();
        chk(par_a == '0 && par_b == '0, "R1 mid-run store cleared", {par_a, par_b}, 0);
        chk(slow_a == 1'b0 && fast_a == 1'b0, "R1 mid-run cascade cleared", {fast_a, slow_a}, 0);
        rst = 1'b0;
        strobe = 1'b0;
        for (int i = 0; i < 10; i++) cycle(1'b1, i > 7, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule